// File: doc/BRIEF.md
# Dual Programmable Audio Clock Divider

This block produces two audio clocks, a master clock and a serial bit clock, from one of two source clocks. Both sources arrive as clock-enable strobes in the system clock domain. A select input picks the source, and each output has its own 6-bit divisor N. A non-zero N gives a 50% duty square wave with a period of 2×N source strobes. N = 0 bypasses the divider, so the output follows the selected source strobe.

Each divided output also has a one-cycle tick that marks the start of every new period, for logic that runs on the audio clock. Separate start and stop command pulses run or halt both dividers together. The divisors are captured only at start. A master-clock enable gates the master output without disturbing its divider.

Top module: `audio_clk_div`

## Requirements
- R1: After reset the divider is stopped: `running`, `mck_out`, `mck_tick`, `sck_out` and `sck_tick` are all 0.
- R2: A `cmd_start` pulse while stopped sets `running` at the next edge. A `cmd_stop` pulse clears it at the next edge. When both pulses arrive in the same cycle, the stop wins.
- R3: With a divisor N from 1 to 63, the output toggles on every Nth selected source strobe, which gives a period of 2×N strobes. The first transition after a start is a rise, on the Nth strobe.
- R4: A tick is high for exactly the one cycle in which its divided output rises, and is low at all other times while N is non-zero.
- R5: With a divisor of 0 and the divider running, the output and its tick both equal the selected source strobe delayed by one register stage.
- R6: `src_sel` = 0 selects `pclk_tick` as the source and `src_sel` = 1 selects `gclk_tick`. The strobe that is not selected has no effect.
- R7: While `mck_out_en` = 0, `mck_out` and `mck_tick` are held at 0. The master divider keeps counting, so raising the enable again shows the current phase.
- R8: `mck_div` and `sck_div` are captured only by the start command. Changing them while running has no effect until the next stop and start.
- R9: A stop forces both outputs and ticks low and clears both counters. A restart therefore begins a fresh period, as R3 describes.
- R10: The largest divisor, 63, gives a period of 126 source strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Source select: 0 peripheral strobe, 1 generated strobe |
| pclk_tick | input | 1 | Peripheral source clock strobe |
| gclk_tick | input | 1 | Generated source clock strobe |
| mck_div | input | 6 | Master-clock divisor N (0 = bypass) |
| sck_div | input | 6 | Bit-clock divisor N (0 = bypass) |
| mck_out_en | input | 1 | 1 drives the master clock out, 0 holds it low |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| running | output | 1 | Dividers are active |
| mck_out | output | 1 | Divided master clock |
| mck_tick | output | 1 | Master-clock period-start strobe |
| sck_out | output | 1 | Divided bit clock |
| sck_tick | output | 1 | Bit-clock period-start strobe |

## Verification
The assertions take the mode input `mck_out_en` as a quasi-static level. They place no limit on how often the strobes or the commands arrive, and they read the captured divisors rather than the input pins. The stimulus drives the strobes as a steady high, as a random half-density stream, or through a source switch made while running. It changes the divisor pins mid-run to show they are ignored. It also issues start and stop in the same cycle, both while stopped and while running. A behavioural model is compared with all five outputs on every clock.

// File: rtl/audio_clk_div.sv
module audio_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             pclk_tick,
  input  logic             gclk_tick,
  input  logic [DIV_W-1:0] mck_div,
  input  logic [DIV_W-1:0] sck_div,
  input  logic             mck_out_en,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  output logic             running,
  output logic             mck_out,
  output logic             mck_tick,
  output logic             sck_out,
  output logic             sck_tick
);
  localparam int NDIV = 2;

  logic             src_tick;
  logic             run_q;
  logic             start_now;
  logic [DIV_W-1:0] n_q   [NDIV];
  logic [DIV_W-1:0] cnt_q [NDIV];
  logic             out_q [NDIV];
  logic             tick_q[NDIV];

  assign src_tick  = src_sel ? gclk_tick : pclk_tick;
  assign start_now = cmd_start & ~cmd_stop & ~run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (cmd_stop) run_q <= 1'b0;
    else if (cmd_start) run_q <= 1'b1;
  end

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    logic [DIV_W-1:0] div_in;
    assign div_in = (i == 0) ? mck_div : sck_div;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        n_q[i]    <= '0;
        cnt_q[i]  <= '0;
        out_q[i]  <= 1'b0;
        tick_q[i] <= 1'b0;
      end else if (!run_q || cmd_stop) begin
        cnt_q[i]  <= '0;
        out_q[i]  <= 1'b0;
        tick_q[i] <= 1'b0;
        if (start_now) n_q[i] <= div_in;
      end else if (n_q[i] == '0) begin
        out_q[i]  <= src_tick;
        tick_q[i] <= src_tick;
      end else begin
        tick_q[i] <= 1'b0;
        if (src_tick) begin
          if (cnt_q[i] == n_q[i] - DIV_W'(1)) begin
            cnt_q[i]  <= '0;
            out_q[i]  <= ~out_q[i];
            tick_q[i] <= ~out_q[i];
          end else begin
            cnt_q[i] <= cnt_q[i] + DIV_W'(1);
          end
        end
      end
    end
  end

  assign running  = run_q;
  assign mck_out  = out_q[0]  & mck_out_en;
  assign mck_tick = tick_q[0] & mck_out_en;
  assign sck_out  = out_q[1];
  assign sck_tick = tick_q[1];
endmodule

// File: rtl/audio_clk_div_chk.sv
module audio_clk_div_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             mck_out_en,
  input logic             running,
  input logic             mck_out,
  input logic             mck_tick,
  input logic             sck_out,
  input logic             sck_tick,
  input logic [DIV_W-1:0] mck_n,
  input logic [DIV_W-1:0] sck_n,
  input logic [DIV_W-1:0] sck_cnt
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!mck_out && !sck_out && !mck_tick && !sck_tick));

  assert_stop_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !running);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_stop) |=> running);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sck_n != '0) |-> (sck_cnt < sck_n));

  assert_tick_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_tick && sck_n != '0) |-> $rose(sck_out));

  assert_bypass_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sck_n == '0) |-> (sck_out == sck_tick));

  assert_mck_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mck_out_en |-> (!mck_out && !mck_tick));

  assert_div_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(mck_n) && $stable(sck_n)));
endmodule

bind audio_clk_div audio_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .mck_out_en(mck_out_en), .running(running), .mck_out(mck_out),
  .mck_tick(mck_tick), .sck_out(sck_out), .sck_tick(sck_tick),
  .mck_n(n_q[0]), .sck_n(n_q[1]), .sck_cnt(cnt_q[1])
);

// File: tb/sim_audio_clk_div.sv
`timescale 1ns/1ps
module sim_audio_clk_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0, pclk_tick = 1'b0, gclk_tick = 1'b0;
  logic [5:0] mck_div = '0, sck_div = '0;
  logic mck_out_en = 1'b1, cmd_start = 1'b0, cmd_stop = 1'b0;
  logic running, mck_out, mck_tick, sck_out, sck_tick;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit p_steady = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pclk_tick(pclk_tick),
    .gclk_tick(gclk_tick), .mck_div(mck_div), .sck_div(sck_div),
    .mck_out_en(mck_out_en), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .running(running), .mck_out(mck_out), .mck_tick(mck_tick),
    .sck_out(sck_out), .sck_tick(sck_tick));

  // behavioural reference
  int m_run, m_n[2], m_c[2], m_o[2], m_t[2];
  int sck_rises;

  always @(posedge clk) begin
    int tk;
    cycles++;
    if (!rst_n) begin
      m_run = 0;
      for (int i = 0; i < 2; i++) begin m_n[i] = 0; m_c[i] = 0; m_o[i] = 0; m_t[i] = 0; end
    end else begin
      tk = src_sel ? int'(gclk_tick) : int'(pclk_tick);
      if (cmd_stop || !m_run) begin
        if (!cmd_stop && cmd_start) begin
          m_n[0] = mck_div; m_n[1] = sck_div;
        end
        m_run = (!cmd_stop && cmd_start) ? 1 : 0;
        for (int i = 0; i < 2; i++) begin m_c[i] = 0; m_o[i] = 0; m_t[i] = 0; end
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (m_n[i] == 0) begin
            m_o[i] = tk; m_t[i] = tk;
          end else begin
            m_t[i] = 0;
            if (tk == 1) begin
              m_c[i]++;
              if (m_c[i] == m_n[i]) begin
                m_c[i] = 0;
                m_o[i] = 1 - m_o[i];
                m_t[i] = m_o[i];
                if (i == 1 && m_o[i] == 1) sck_rises++;
              end
            end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic step();
    int eo, et;
    @(negedge clk);
    eo = mck_out_en ? m_o[0] : 0;
    et = mck_out_en ? m_t[0] : 0;
    chk(cur_req, "running", running, m_run);
    chk(cur_req, "mck_out", mck_out, eo);
    chk(cur_req, "mck_tick", mck_tick, et);
    chk(cur_req, "sck_out", sck_out, m_o[1]);
    chk(cur_req, "sck_tick", sck_tick, m_t[1]);
    cmd_start = 1'b0;
    cmd_stop  = 1'b0;
    pclk_tick = p_steady ? 1'b1 : 1'($urandom % 2);
    gclk_tick = 1'($urandom % 2);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    @(negedge clk);
    chk("R1", "running after reset", running, 0);
    chk("R1", "outputs after reset", {mck_out, mck_tick, sck_out, sck_tick}, 0);
    cur_req = "R1"; run(5);

    // R3 / R4: steady peripheral strobe, divisors 3 and 5
    cur_req = "R3"; mck_div = 6'd3; sck_div = 6'd5; src_sel = 1'b0; p_steady = 1'b1;
    cmd_start = 1'b1; run(1);
    chk("R2", "running after start", running, 1);
    run(4);
    chk("R3", "sck still low before 5th strobe", sck_out, 0);
    run(2);
    chk("R3", "sck rose on 5th strobe", sck_out, 1);
    cur_req = "R4"; run(200);

    // R6: switch to sparse generated strobe, peripheral kept high
    cur_req = "R6"; src_sel = 1'b1; run(300);

    // R8: divisor pins changed while running
    cur_req = "R8"; mck_div = 6'd1; sck_div = 6'd2; run(150);

    // R9: stop clears, restart begins fresh
    cur_req = "R9"; cmd_stop = 1'b1; run(1);
    chk("R9", "outputs after stop", {mck_out, mck_tick, sck_out, sck_tick}, 0);
    run(5);
    src_sel = 1'b0; p_steady = 1'b0; cmd_start = 1'b1; run(120);

    // R5 / R10: bypass on master, maximum divisor on bit clock
    cur_req = "R5"; cmd_stop = 1'b1; run(3);
    mck_div = 6'd0; sck_div = 6'd63; p_steady = 1'b1; cmd_start = 1'b1; run(1);
    sck_rises = 0;
    cur_req = "R10"; run(63 + 126 * 3 + 2);
    chk("R10", "bit clock rises in 3 periods of 126", sck_rises, 4);

    // R7: master output gated
    cur_req = "R7"; mck_out_en = 1'b0; run(60);
    mck_out_en = 1'b1; run(20);

    // R2: start and stop together, both while running and while stopped
    cur_req = "R2"; cmd_start = 1'b1; cmd_stop = 1'b1; run(1);
    chk("R2", "stop wins while running", running, 0);
    cmd_start = 1'b1; cmd_stop = 1'b1; run(1);
    chk("R2", "stop wins while stopped", running, 0);
    cmd_start = 1'b1; run(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0 at cycle %0d", 1, cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule